// File: doc/BRIEF.md
# Writeback Queue with Register Hazard Search

This block holds the in-order list of register writebacks that an issue stage has launched but that have not yet retired. Each record is one of four kinds: an ALU result (destination index and 32-bit value), a load (destination index only), a store, or a host operation (neither writes a register). Records leave in the order they entered. The oldest record is always visible at the head outputs, and one command discards the whole queue.

The queue can be searched associatively. Two search ports work side by side in the same cycle, each with its own register index. A port hits when any occupied slot holds an ALU or load record whose destination equals the index. An operand-policy stage sits in front of the ports. It takes the issuing instruction's class code and its three operand indices, picks which indices go to which port, and raises `stall` while a needed register is still pending.

The occupancy controller is a three-state machine. The states are `Q_EMPTY`, `Q_PART` and `Q_FULL`.
- From `Q_EMPTY`, an accepted push moves it to `Q_PART`, or to `Q_FULL` when the depth is 1.
- In `Q_PART`, a push alone that fills the last slot moves it to `Q_FULL`. A pop alone of the last record moves it to `Q_EMPTY`.
- From `Q_FULL`, an accepted pop moves it to `Q_PART`.
- A clear moves every state to `Q_EMPTY`.

Top module: `wbq_hazard_top`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, and `stall`, `hit_a` and `hit_b` are 0.
- R2: Records leave in the order they entered. The head outputs show the oldest record's tag, destination and data. Tag codes are 0 for ALU, 1 for load, 2 for store and 3 for host. A record pushed into an empty queue appears at the head after the next rising edge. A push and a pop in the same cycle are both accepted when the queue is neither empty nor full.
- R3: `full` rises after DEPTH (default 4) accepted pushes. A push while full is ignored, even when a pop happens in the same cycle, and the queue contents stay unchanged.
- R4: A pop while empty is ignored. The queue stays empty, and later pushes behave normally.
- R5: A search hits only on an occupied ALU or load record whose destination equals the query index. Store and host records never hit, whatever their destination field holds.
- R6: The two ports answer independently in the same cycle for different indices: `hit_a` reflects the port A index and `hit_b` the port B index.
- R7: The class codes check only `src1` on port A in these cases: 0 (load base), 2 (immediate ALU), 3 (constant shift), 4 (one-register branch), 5 (register jump) and 6 (move to coprocessor). Class 1 (store) checks `src1` on port A and `src2` on port B.
- R8: Classes 7 (register-register ALU), 8 (variable shift) and 9 (two-register branch) check `src1` on port A and `src2` on port B.
- R9: Class 10 (load-upper-immediate) checks `dst` on port A. Classes 11 (absolute jump), 12 (jump-and-link to target), 13 (move from coprocessor), 14 and 15 (unrecognised) never stall.
- R10: A clear empties the queue in one cycle and wins over a push or a pop in the same cycle. After it, no search hits.
- R11: A slot that has been popped or cleared never produces a hit, even though its old contents remain.
- R12: Searches see the contents from before any pop in the same cycle, so a record being popped still causes a hit in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Push a record |
| enq_tag | input | 2 | Record kind (0 ALU, 1 load, 2 store, 3 host) |
| enq_dest | input | 5 | Destination register index |
| enq_data | input | 32 | ALU result value |
| deq | input | 1 | Pop the head record |
| clr | input | 1 | Discard all records |
| head_tag | output | 2 | Tag of the oldest record |
| head_dest | output | 5 | Destination of the oldest record |
| head_data | output | 32 | Data of the oldest record |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slot occupied |
| ic_class | input | 4 | Instruction class code of the issuing instruction |
| ic_src1 | input | 5 | First source operand index |
| ic_src2 | input | 5 | Second source operand index |
| ic_dst | input | 5 | Destination operand index |
| hit_a | output | 1 | Port A query is pending |
| hit_b | output | 1 | Port B query is pending |
| stall | output | 1 | Issuing instruction must wait |

## Verification
`hit_a`, `hit_b` and `stall` are combinational on the current contents and the class and operand inputs, so they are due in the same cycle as the query. Pushes, pops and clears take effect at the next rising edge, after which the head, `full`, `empty` and the hits reflect the new contents. The bench drives inputs just after a falling edge. It compares every output once before the rising edge, which checks the search against the contents from before the edge (this is how the same-cycle pop case is covered). It compares them again after the following falling edge, against a reference model updated at the edge.

// File: rtl/wbq_pkg.sv
package wbq_pkg;
    localparam int REG_W  = 5;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        WB_ALU   = 2'd0,
        WB_LOAD  = 2'd1,
        WB_STORE = 2'd2,
        WB_HOST  = 2'd3
    } wb_tag_e;

    typedef struct packed {
        wb_tag_e             tag;
        logic [REG_W-1:0]    dest;
        logic [DATA_W-1:0]   data;
    } wb_rec_t;

    typedef enum logic [3:0] {
        IC_LOAD        = 4'd0,
        IC_STORE       = 4'd1,
        IC_IMM_ALU     = 4'd2,
        IC_SHIFT_CONST = 4'd3,
        IC_BRANCH_ONE  = 4'd4,
        IC_JUMP_REG    = 4'd5,
        IC_MOVE_TO_COP = 4'd6,
        IC_REG_ALU     = 4'd7,
        IC_SHIFT_VAR   = 4'd8,
        IC_BRANCH_TWO  = 4'd9,
        IC_LOAD_UPPER  = 4'd10,
        IC_JUMP_ABS    = 4'd11,
        IC_JUMP_LINK   = 4'd12,
        IC_MOVE_FROM   = 4'd13,
        IC_OTHER_A     = 4'd14,
        IC_OTHER_B     = 4'd15
    } icls_e;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } qstate_e;
endpackage

// File: rtl/wbq_store.sv
module wbq_store
    import wbq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  wb_rec_t           push_rec,
    input  logic              pop,
    input  logic              clr,
    output wb_rec_t           head_rec,
    output logic              full,
    output logic              empty,
    input  logic [REG_W-1:0]  qa_idx,
    input  logic [REG_W-1:0]  qb_idx,
    output logic              qa_hit,
    output logic              qb_hit
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    qstate_e            state, state_nx;
    logic [PTR_W-1:0]   rd_ptr, wr_ptr;
    logic [CNT_W-1:0]   cnt;
    wb_rec_t            slots [DEPTH];
    logic [DEPTH-1:0]   occ;
    logic [DEPTH-1:0]   match_a, match_b;
    logic               push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_ok = push && !clr && (state != Q_FULL);
    assign pop_ok  = pop  && !clr && (state != Q_EMPTY);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= Q_EMPTY;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (clr) begin
            state_nx = Q_EMPTY;
        end else begin
            unique case (state)
                Q_EMPTY: if (push_ok) state_nx = (DEPTH == 1) ? Q_FULL : Q_PART;
                Q_PART: begin
                    if (push_ok && !pop_ok && cnt == CNT_W'(DEPTH - 1))
                        state_nx = Q_FULL;
                    else if (pop_ok && !push_ok && cnt == CNT_W'(1))
                        state_nx = Q_EMPTY;
                end
                Q_FULL:  if (pop_ok) state_nx = (DEPTH == 1) ? Q_EMPTY : Q_PART;
                default: state_nx = Q_EMPTY;
            endcase
        end
    end

    // outputs from state
    always_comb begin
        full     = (state == Q_FULL);
        empty    = (state == Q_EMPTY);
        head_rec = slots[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                occ[g] <= 1'b0;
            end else if (push_ok && wr_ptr == PTR_W'(g)) begin
                occ[g] <= 1'b1;
            end else if (pop_ok && rd_ptr == PTR_W'(g)) begin
                occ[g] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                slots[g] <= '0;
            else if (push_ok && wr_ptr == PTR_W'(g))
                slots[g] <= push_rec;
        end

        logic writes_reg;
        assign writes_reg = occ[g] && (slots[g].tag == WB_ALU || slots[g].tag == WB_LOAD);
        assign match_a[g] = writes_reg && (slots[g].dest == qa_idx);
        assign match_b[g] = writes_reg && (slots[g].dest == qb_idx);
    end

    assign qa_hit = |match_a;
    assign qb_hit = |match_b;
endmodule

// File: rtl/wbq_operand_policy.sv
module wbq_operand_policy
    import wbq_pkg::*;
(
    input  icls_e             cls,
    input  logic [REG_W-1:0]  src1,
    input  logic [REG_W-1:0]  src2,
    input  logic [REG_W-1:0]  dst,
    output logic              a_en,
    output logic [REG_W-1:0]  a_idx,
    output logic              b_en,
    output logic [REG_W-1:0]  b_idx
);
    always_comb begin
        a_en  = 1'b0;
        a_idx = src1;
        b_en  = 1'b0;
        b_idx = src2;
        case (cls)
            IC_LOAD, IC_IMM_ALU, IC_SHIFT_CONST,
            IC_BRANCH_ONE, IC_JUMP_REG, IC_MOVE_TO_COP: a_en = 1'b1;
            IC_STORE, IC_REG_ALU, IC_SHIFT_VAR, IC_BRANCH_TWO: begin
                a_en = 1'b1;
                b_en = 1'b1;
            end
            IC_LOAD_UPPER: begin
                a_en  = 1'b1;
                a_idx = dst;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wbq_hazard_top.sv
module wbq_hazard_top
    import wbq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enq_valid,
    input  logic [1:0]   enq_tag,
    input  logic [4:0]   enq_dest,
    input  logic [31:0]  enq_data,
    input  logic         deq,
    input  logic         clr,
    output logic [1:0]   head_tag,
    output logic [4:0]   head_dest,
    output logic [31:0]  head_data,
    output logic         full,
    output logic         empty,
    input  logic [3:0]   ic_class,
    input  logic [4:0]   ic_src1,
    input  logic [4:0]   ic_src2,
    input  logic [4:0]   ic_dst,
    output logic         hit_a,
    output logic         hit_b,
    output logic         stall
);
    wb_rec_t           in_rec, hd_rec;
    logic              a_en, b_en, qa_hit, qb_hit;
    logic [REG_W-1:0]  a_idx, b_idx;

    assign in_rec = '{tag: wb_tag_e'(enq_tag), dest: enq_dest, data: enq_data};

    wbq_operand_policy u_policy (
        .cls  (icls_e'(ic_class)),
        .src1 (ic_src1),
        .src2 (ic_src2),
        .dst  (ic_dst),
        .a_en (a_en),
        .a_idx(a_idx),
        .b_en (b_en),
        .b_idx(b_idx)
    );

    wbq_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (enq_valid),
        .push_rec(in_rec),
        .pop     (deq),
        .clr     (clr),
        .head_rec(hd_rec),
        .full    (full),
        .empty   (empty),
        .qa_idx  (a_idx),
        .qb_idx  (b_idx),
        .qa_hit  (qa_hit),
        .qb_hit  (qb_hit)
    );

    assign head_tag  = hd_rec.tag;
    assign head_dest = hd_rec.dest;
    assign head_data = hd_rec.data;
    assign hit_a     = a_en && qa_hit;
    assign hit_b     = b_en && qb_hit;
    assign stall     = hit_a || hit_b;
endmodule

// File: rtl/wbq_hazard_chk.sv
module wbq_hazard_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        enq_valid,
    input logic        deq,
    input logic        clr,
    input logic        full,
    input logic        empty,
    input logic        stall,
    input logic [31:0] head_data,
    input logic [3:0]  ic_class
);
    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (empty && !full));

    // R3
    full_push_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && enq_valid && !deq && !clr) |=> (full && $stable(head_data)));

    // R4
    empty_pop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && deq && !enq_valid && !clr) |=> empty);

    // R10
    clear_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (empty && !stall));

    // R11
    empty_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !stall);

    // R9
    free_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ic_class >= 4'd11) |-> !stall);

    // R3
    full_xor_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

bind wbq_hazard_top wbq_hazard_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enq_valid(enq_valid),
    .deq      (deq),
    .clr      (clr),
    .full     (full),
    .empty    (empty),
    .stall    (stall),
    .head_data(head_data),
    .ic_class (ic_class)
);

// File: tb/wbq_hazard_top_bench.sv
module wbq_hazard_top_bench;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enq_valid = 1'b0, deq = 1'b0, clr = 1'b0;
    logic [1:0]  enq_tag = '0;
    logic [4:0]  enq_dest = '0;
    logic [31:0] enq_data = '0;
    logic [3:0]  ic_class = 4'd15;
    logic [4:0]  ic_src1 = '0, ic_src2 = '0, ic_dst = '0;
    logic [1:0]  head_tag;
    logic [4:0]  head_dest;
    logic [31:0] head_data;
    logic        full, empty, hit_a, hit_b, stall;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    typedef struct { logic [1:0] tag; logic [4:0] dest; logic [31:0] data; } ent_t;
    ent_t model_q[$];

    always #2 clk = ~clk;

    wbq_hazard_top #(.DEPTH(DEPTH)) u_wbq_hazard_top (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_tag(enq_tag),
        .enq_dest(enq_dest), .enq_data(enq_data), .deq(deq), .clr(clr),
        .head_tag(head_tag), .head_dest(head_dest), .head_data(head_data),
        .full(full), .empty(empty), .ic_class(ic_class), .ic_src1(ic_src1),
        .ic_src2(ic_src2), .ic_dst(ic_dst), .hit_a(hit_a), .hit_b(hit_b),
        .stall(stall)
    );

    task automatic cmp(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic bit pending(input logic [4:0] idx);
        foreach (model_q[i])
            if (model_q[i].tag <= 2'd1 && model_q[i].dest == idx) return 1'b1;
        return 1'b0;
    endfunction

    // Expected port results from the class rules
    task automatic expect_hits(output bit ea, output bit eb);
        ea = 0;
        eb = 0;
        if (ic_class <= 4'd9)       ea = pending(ic_src1);
        else if (ic_class == 4'd10) ea = pending(ic_dst);
        if (ic_class == 4'd1 || (ic_class >= 4'd7 && ic_class <= 4'd9)) eb = pending(ic_src2);
    endtask

    task automatic check_all(input string req);
        bit ea, eb;
        expect_hits(ea, eb);
        cmp(req, "empty", 32'(empty), 32'(model_q.size() == 0));
        cmp(req, "full", 32'(full), 32'(model_q.size() == DEPTH));
        cmp(req, "hit_a", 32'(hit_a), 32'(ea));
        cmp(req, "hit_b", 32'(hit_b), 32'(eb));
        cmp(req, "stall", 32'(stall), 32'(ea || eb));
    endtask

    // Driver: applies one cycle of commands and keeps the expected queue
    task automatic step(input bit e, input logic [1:0] t, input logic [4:0] d,
                        input logic [31:0] v, input bit p, input bit c, input string req);
        ent_t front;
        int sz;
        @(negedge clk);
        enq_valid = e; enq_tag = t; enq_dest = d; enq_data = v; deq = p; clr = c;
        #1;
        check_all(req);
        @(posedge clk);
        sz = model_q.size();
        if (c) begin
            model_q.delete();
        end else begin
            if (p && sz > 0) begin
                front = model_q.pop_front();
                // Monitor: popped head must match oldest expected record
                cmp("R2", "head_tag", 32'(head_tag), 32'(front.tag));
                cmp("R2", "head_dest", 32'(head_dest), 32'(front.dest));
                cmp("R2", "head_data", head_data, front.data);
            end
            if (e && sz < DEPTH) model_q.push_back('{t, d, v});
        end
        @(negedge clk);
        enq_valid = 0; deq = 0; clr = 0;
        #1;
        check_all(req);
    endtask

    task automatic query(input logic [3:0] cls, input logic [4:0] s1, input logic [4:0] s2,
                         input logic [4:0] d, input string req);
        @(negedge clk);
        ic_class = cls; ic_src1 = s1; ic_src2 = s2; ic_dst = d;
        #1;
        check_all(req);
    endtask

    function automatic string class_req(input int c);
        if (c <= 6) return "R7";
        if (c <= 9) return "R8";
        return "R9";
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        cmp("R1", "empty", 32'(empty), 32'd1);
        cmp("R1", "full", 32'(full), 32'd0);
        cmp("R1", "stall", 32'(stall), 32'd0);
        cmp("R1", "hits", 32'({hit_a, hit_b}), 32'd0);

        // R2 / R5 fill with every record kind
        step(1, 2'd0, 5'd5,  32'hAAAA_0005, 0, 0, "R2");
        query(4'd2, 5'd5, 5'd0, 5'd0, "R5");
        step(1, 2'd1, 5'd7,  32'h0, 0, 0, "R2");
        step(1, 2'd2, 5'd9,  32'h9999_0009, 0, 0, "R5");
        step(1, 2'd3, 5'd11, 32'hBBBB_000B, 0, 0, "R3");
        // R5 store and host records never hit
        query(4'd7, 5'd9, 5'd11, 5'd0, "R5");
        // R6 two ports, different indices, same cycle
        query(4'd7, 5'd7, 5'd5, 5'd0, "R6");
        query(4'd7, 5'd7, 5'd0, 5'd0, "R6");
        query(4'd7, 5'd0, 5'd5, 5'd0, "R6");
        // R3 push while full ignored
        step(1, 2'd0, 5'd20, 32'hDEAD_0020, 0, 0, "R3");
        query(4'd2, 5'd20, 5'd0, 5'd0, "R3");
        // R3 push with pop while full: push dropped
        step(1, 2'd0, 5'd21, 32'hDEAD_0021, 1, 0, "R3");
        query(4'd2, 5'd21, 5'd0, 5'd0, "R3");
        step(1, 2'd0, 5'd5, 32'hCCCC_0005, 0, 0, "R2");

        // R7 R8 R9 class policy against pending registers 7 and 5
        for (int c = 0; c < 16; c++) begin
            query(4'(c), 5'd7, 5'd0, 5'd0, class_req(c));
            query(4'(c), 5'd0, 5'd5, 5'd0, class_req(c));
            query(4'(c), 5'd0, 5'd0, 5'd7, class_req(c));
            query(4'(c), 5'd9, 5'd11, 5'd11, class_req(c));
        end

        // R12 pop of the matching head still hits in that cycle
        query(4'd2, 5'd7, 5'd0, 5'd0, "R12");
        step(0, 2'd0, 5'd0, 32'h0, 1, 0, "R12");
        step(0, 2'd0, 5'd0, 32'h0, 1, 0, "R11");
        step(0, 2'd0, 5'd0, 32'h0, 1, 0, "R11");
        query(4'd7, 5'd5, 5'd7, 5'd0, "R11");
        step(0, 2'd0, 5'd0, 32'h0, 1, 0, "R11");
        // R4 pop while empty ignored; stale slots stay silent
        step(0, 2'd0, 5'd0, 32'h0, 1, 0, "R4");
        query(4'd7, 5'd5, 5'd7, 5'd0, "R11");
        step(1, 2'd1, 5'd3, 32'h0, 0, 0, "R4");
        query(4'd0, 5'd3, 5'd0, 5'd0, "R4");

        // R2 wrap-around with simultaneous push and pop
        for (int k = 0; k < 6; k++)
            step(1, 2'd0, 5'(k + 12), 32'h1000_0000 + 32'(k), 1, 0, "R2");
        step(1, 2'd0, 5'd30, 32'h3030_3030, 0, 0, "R2");

        // R10 clear wins over push and pop
        query(4'd9, 5'd17, 5'd30, 5'd0, "R10");
        step(1, 2'd0, 5'd17, 32'h0, 1, 1, "R10");
        query(4'd9, 5'd17, 5'd30, 5'd0, "R10");
        step(1, 2'd1, 5'd4, 32'h0, 0, 0, "R10");
        query(4'd10, 5'd0, 5'd0, 5'd4, "R9");
        step(0, 2'd0, 5'd0, 32'h0, 1, 0, "R2");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule